// File: doc/BRIEF.md
# Shared Last-Level Registry Bank

This block is one bank of a shared last-level cache that serves the misses of several private first-level caches. Every word entry of its data array has a one-bit flag. When the flag is clear the entry holds the current data value. When the flag is set, the low bits of the same field hold the id of the one core that has registered the word. There is no separate directory and no list of sharers. The bank tracks only where the single up-to-date copy lives, and it keeps no per-entry transient states.

Cores send fetch, register and writeback requests on per-core request lines, and a round-robin arbiter accepts one request per cycle. A fetch of an unregistered word returns the stored data at once. A fetch of a registered word is forwarded to the owning core. The bank then accepts no new requests until that owner answers, and it passes the answer to the requester. Backing memory is not modelled: at reset every entry is loaded with a value computed from its address.

Top module: `l2_reg_bank`

## Requirements
- R1: After reset every entry is unregistered and holds the value ((addr*273) mod 2^16) XOR 0xA5A5. No response, forward or grant is asserted while no request is pending.
- R2: A fetch (kind 0) of an unregistered word raises resp_valid_o for the requester in the cycle after the grant, with resp_ack_o=0 and resp_data_o equal to the stored value.
- R3: A register (kind 1) from core C sets the entry's owner to C, replacing any earlier owner. The cycle after the grant it raises resp_valid_o[C] with resp_ack_o=1.
- R4: A fetch of a registered word pulses fwd_valid_o for one cycle, the cycle after the grant. With it, fwd_owner_o gives the owner, fwd_addr_o the word and fwd_dest_o the requester. No request is granted from then until the owner's reply has been taken.
- R5: When fwd_rsp_valid_i is seen while a forward is pending, the requester gets resp_valid_o with resp_ack_o=0 and the reply data in the next cycle. The registration is left unchanged.
- R6: A writeback (kind 2) from the registered owner stores its data and clears the registration, so later fetches return that data directly. A writeback gives no response.
- R7: A writeback from a core that is not the owner, or to an unregistered word, is ignored.
- R8: At most one request is granted per cycle, always to a core that is requesting. The search starts at the core after the one granted last, from core 0 after reset.
- R9: Kind 3 is granted but changes no entry and produces no response and no forward.
- R10: req_ready_o[c] is the grant, visible combinationally in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_CORES | Request pending, one bit per core |
| req_kind_i | input | 2*N_CORES | Request kind per core (0 fetch, 1 register, 2 writeback, 3 none) |
| req_addr_i | input | ADDR_W*N_CORES | Word address per core |
| req_data_i | input | DATA_W*N_CORES | Writeback data per core |
| req_ready_o | output | N_CORES | Grant, one-hot or zero |
| resp_valid_o | output | N_CORES | Response strobe per core |
| resp_ack_o | output | 1 | 1 for register acknowledge, 0 for data |
| resp_data_o | output | DATA_W | Response data |
| fwd_valid_o | output | 1 | Forward request strobe |
| fwd_owner_o | output | CID_W | Core the fetch is forwarded to |
| fwd_addr_o | output | ADDR_W | Forwarded word address |
| fwd_dest_o | output | CID_W | Core waiting for the data |
| fwd_rsp_valid_i | input | 1 | Owner reply strobe |
| fwd_rsp_data_i | input | DATA_W | Owner reply data |

## Verification
On every cycle the assertions check several properties. Grants are one-hot and go only to requesting cores, and the arbiter stays stalled while a forward is pending. A register is acknowledged, and a fetch of a registered word forwards to the owner, in the following cycle. Kind 3 stays silent, and every array write lands in the entry it targets. Some behaviour shows only across sequences of requests, so only the bench's scenarios can show it: preloaded values, replacement of an owner, a registration that survives a forwarded fetch, writebacks from non-owners being ignored, and the rotation order of the arbiter under different request masks.

// File: rtl/l2rb_pkg.sv
package l2rb_pkg;
  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_REG   = 2'd1,
    K_WB    = 2'd2,
    K_NOP   = 2'd3
  } req_kind_e;
endpackage

// File: rtl/l2rb_rr_arb.sv
module l2rb_rr_arb #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] gnt_idx_o,
  output logic             gnt_any_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    gnt_any_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr_q) + k) % N;
      if (!gnt_any_o && en_i && req_i[j]) begin
        gnt_any_o = 1'b1;
        gnt_o[j]  = 1'b1;
        gnt_idx_o = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (gnt_any_o) ptr_q <= (int'(gnt_idx_o) == N-1) ? '0 : gnt_idx_o + 1'b1;
  end

  a_r8_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gnt_o));
  a_r8_only_requesters: assert property (@(posedge clk_i) disable iff (!rst_ni) (gnt_o & ~req_i) == '0);
  a_r8_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_any_o && $countones(req_i) > 1 |=> !gnt_o[$past(gnt_idx_o)] || !$past(req_i[gnt_idx_o]) || !en_i
      || $countones(req_i) <= 1);
endmodule

// File: rtl/l2rb_array.sv
module l2rb_array #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int INIT_MUL = 273,
  parameter int INIT_XOR = 42405,
  localparam int DEPTH   = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              rowned_o,
  output logic [DATA_W-1:0] rfield_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wowned_i,
  input  logic [DATA_W-1:0] wfield_i
);
  logic [DATA_W-1:0] field_q [DEPTH];
  logic [DEPTH-1:0]  owned_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owned_q <= '0;
      for (int a = 0; a < DEPTH; a++)
        field_q[a] <= DATA_W'(a * INIT_MUL) ^ DATA_W'(INIT_XOR);
    end else if (we_i) begin
      owned_q[waddr_i] <= wowned_i;
      field_q[waddr_i] <= wfield_i;
    end
  end

  assign rowned_o = owned_q[raddr_i];
  assign rfield_o = field_q[raddr_i];

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> owned_q[$past(waddr_i)] == $past(wowned_i) && field_q[$past(waddr_i)] == $past(wfield_i));
endmodule

// File: rtl/l2_reg_bank.sv
module l2_reg_bank #(
  parameter int N_CORES  = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int INIT_MUL = 273,
  parameter int INIT_XOR = 42405,
  localparam int CID_W   = $clog2(N_CORES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CORES-1:0]        req_valid_i,
  input  logic [2*N_CORES-1:0]      req_kind_i,
  input  logic [ADDR_W*N_CORES-1:0] req_addr_i,
  input  logic [DATA_W*N_CORES-1:0] req_data_i,
  output logic [N_CORES-1:0]        req_ready_o,
  output logic [N_CORES-1:0]        resp_valid_o,
  output logic                      resp_ack_o,
  output logic [DATA_W-1:0]         resp_data_o,
  output logic                      fwd_valid_o,
  output logic [CID_W-1:0]          fwd_owner_o,
  output logic [ADDR_W-1:0]         fwd_addr_o,
  output logic [CID_W-1:0]          fwd_dest_o,
  input  logic                      fwd_rsp_valid_i,
  input  logic [DATA_W-1:0]         fwd_rsp_data_i
);
  import l2rb_pkg::*;

  logic              busy_q;
  logic [CID_W-1:0]  pend_q;
  logic [CID_W-1:0]  gnt_idx;
  logic              gnt_any;
  req_kind_e         sel_kind;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_data;
  logic              rowned;
  logic [DATA_W-1:0] rfield;
  logic [CID_W-1:0]  owner;
  logic              we, wowned;
  logic [DATA_W-1:0] wfield;

  l2rb_rr_arb #(.N(N_CORES), .IDX_W(CID_W)) u_arb (
    .clk_i, .rst_ni, .en_i(!busy_q), .req_i(req_valid_i),
    .gnt_o(req_ready_o), .gnt_idx_o(gnt_idx), .gnt_any_o(gnt_any)
  );

  assign sel_kind = req_kind_e'(req_kind_i[2*gnt_idx +: 2]);
  assign sel_addr = req_addr_i[ADDR_W*gnt_idx +: ADDR_W];
  assign sel_data = req_data_i[DATA_W*gnt_idx +: DATA_W];

  l2rb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_MUL(INIT_MUL), .INIT_XOR(INIT_XOR)) u_arr (
    .clk_i, .rst_ni, .raddr_i(sel_addr), .rowned_o(rowned), .rfield_o(rfield),
    .we_i(we), .waddr_i(sel_addr), .wowned_i(wowned), .wfield_i(wfield)
  );

  assign owner = rfield[CID_W-1:0];

  // field is reused: owner id in low bits when registered
  always_comb begin
    we     = 1'b0;
    wowned = 1'b0;
    wfield = sel_data;
    if (gnt_any) begin
      unique case (sel_kind)
        K_REG: begin
          we     = 1'b1;
          wowned = 1'b1;
          wfield = DATA_W'(gnt_idx);
        end
        K_WB: if (rowned && owner == gnt_idx) we = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      pend_q       <= '0;
      resp_valid_o <= '0;
      resp_ack_o   <= 1'b0;
      resp_data_o  <= '0;
      fwd_valid_o  <= 1'b0;
      fwd_owner_o  <= '0;
      fwd_addr_o   <= '0;
      fwd_dest_o   <= '0;
    end else begin
      resp_valid_o <= '0;
      fwd_valid_o  <= 1'b0;
      if (busy_q) begin
        if (fwd_rsp_valid_i) begin
          busy_q               <= 1'b0;
          resp_valid_o[pend_q] <= 1'b1;
          resp_ack_o           <= 1'b0;
          resp_data_o          <= fwd_rsp_data_i;
        end
      end else if (gnt_any) begin
        unique case (sel_kind)
          K_FETCH: begin
            if (rowned) begin
              fwd_valid_o <= 1'b1;
              fwd_owner_o <= owner;
              fwd_addr_o  <= sel_addr;
              fwd_dest_o  <= gnt_idx;
              busy_q      <= 1'b1;
              pend_q      <= gnt_idx;
            end else begin
              resp_valid_o[gnt_idx] <= 1'b1;
              resp_ack_o            <= 1'b0;
              resp_data_o           <= rfield;
            end
          end
          K_REG: begin
            resp_valid_o[gnt_idx] <= 1'b1;
            resp_ack_o            <= 1'b1;
            resp_data_o           <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  a_r4_stall: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_q |-> req_ready_o == '0);
  a_r2_resp_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(resp_valid_o));
  a_r3_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_any && sel_kind == K_REG |=> resp_valid_o[$past(gnt_idx)] && resp_ack_o);
  a_r4_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_any && sel_kind == K_FETCH && rowned |=> fwd_valid_o && fwd_owner_o == $past(owner)
      && resp_valid_o == '0);
  a_r5_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && fwd_rsp_valid_i |=> resp_valid_o[$past(pend_q)] && !resp_ack_o
      && resp_data_o == $past(fwd_rsp_data_i));
  a_r9_nop_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_any && sel_kind == K_NOP |=> resp_valid_o == '0 && !fwd_valid_o);
endmodule

// File: tb/sim_l2_reg_bank.sv
module sim_l2_reg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req_valid = '0;
  logic [2*N-1:0] req_kind = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_data = '0;
  logic [N-1:0] req_ready, resp_valid;
  logic resp_ack, fwd_valid, fwd_rsp_valid = 1'b0;
  logic [DW-1:0] resp_data, fwd_rsp_data = '0;
  logic [1:0] fwd_owner, fwd_dest;
  logic [AW-1:0] fwd_addr;

  int checks = 0, errors = 0, rr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_reg_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_data_i(req_data), .req_ready_o(req_ready),
    .resp_valid_o(resp_valid), .resp_ack_o(resp_ack), .resp_data_o(resp_data),
    .fwd_valid_o(fwd_valid), .fwd_owner_o(fwd_owner), .fwd_addr_o(fwd_addr),
    .fwd_dest_o(fwd_dest), .fwd_rsp_valid_i(fwd_rsp_valid), .fwd_rsp_data_i(fwd_rsp_data)
  );

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 273) ^ 16'hA5A5;
  endfunction

  function automatic int next_grant(logic [N-1:0] m, int p);
    for (int k = 0; k < N; k++) if (m[(p + k) % N]) return (p + k) % N;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one request; returns at the negedge after the grant edge
  task automatic send(int c, int k, int a, logic [DW-1:0] d);
    @(negedge clk);
    req_valid = '0;
    req_valid[c] = 1'b1;
    req_kind[2*c +: 2] = 2'(k);
    req_addr[AW*c +: AW] = AW'(a);
    req_data[DW*c +: DW] = d;
    #1;
    chk(req_ready == 4'(1 << c), "R10", "grant same cycle", req_ready, 1 << c);
    rr = (c + 1) % N;
    @(negedge clk);
    req_valid = '0;
  endtask

  task automatic expect_data(int c, logic [DW-1:0] d, string req);
    chk(resp_valid == 4'(1 << c) && !resp_ack && resp_data == d, req, "data response",
        {resp_valid, resp_ack, resp_data}, {4'(1 << c), 1'b0, d});
  endtask

  task automatic fwd_fetch(int c, int a, int own, logic [DW-1:0] reply, string req);
    send(c, 0, a, '0);
    chk(fwd_valid && fwd_owner == 2'(own) && fwd_addr == AW'(a) && fwd_dest == 2'(c)
        && resp_valid == '0, req, "forward", {fwd_valid, fwd_owner, fwd_addr, fwd_dest},
        {1'b1, 2'(own), AW'(a), 2'(c)});
    req_valid[(c + 1) % N] = 1'b1;
    req_kind[2*((c + 1) % N) +: 2] = 2'd3;
    #1;
    chk(req_ready == '0, "R4", "stall while pending", req_ready, 0);
    @(negedge clk);
    chk(!fwd_valid && req_ready == '0, "R4", "one-cycle forward, still stalled", {fwd_valid, req_ready}, 0);
    req_valid = '0;
    fwd_rsp_valid = 1'b1;
    fwd_rsp_data = reply;
    @(negedge clk);
    fwd_rsp_valid = 1'b0;
    expect_data(c, reply, "R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int own [DEPTH];
    repeat (3) @(negedge clk);
    chk(resp_valid == '0 && !fwd_valid && req_ready == '0, "R1", "reset outputs",
        {resp_valid, fwd_valid, req_ready}, 0);
    rst_n = 1'b1;

    for (int a = 0; a < DEPTH; a++) begin
      send(a % N, 0, a, '0);
      expect_data(a % N, pat(a), "R1");
      own[a] = -1;
    end

    for (int a = 0; a < 8; a++) begin
      send(a % N, 1, a, '0);
      chk(resp_valid == 4'(1 << (a % N)) && resp_ack, "R3", "register ack", {resp_valid, resp_ack}, {4'(1 << (a % N)), 1'b1});
      own[a] = a % N;
    end
    for (int a = 0; a < 4; a++) begin
      send((a + 2) % N, 1, a, '0);
      chk(resp_valid == 4'(1 << ((a + 2) % N)) && resp_ack, "R3", "re-register ack", resp_valid, 1 << ((a + 2) % N));
      own[a] = (a + 2) % N;
    end

    for (int a = 0; a < 8; a++) begin
      fwd_fetch((own[a] + 1) % N, a, own[a], 16'hC000 + 16'(a), "R4");
      fwd_fetch((own[a] + 3) % N, a, own[a], 16'hC100 + 16'(a), "R5");
    end

    for (int a = 0; a < 8; a++) begin
      send((own[a] + 1) % N, 2, a, 16'hDEAD);
      chk(resp_valid == '0 && !fwd_valid, "R7", "non-owner writeback silent", resp_valid, 0);
      fwd_fetch(0, a, own[a], 16'hC200 + 16'(a), "R7");
    end
    send(0, 2, 12, 16'hBEEF);
    send(1, 0, 12, '0);
    expect_data(1, pat(12), "R7");

    for (int a = 0; a < 8; a++) begin
      send(own[a], 2, a, 16'hB000 + 16'(a));
      chk(resp_valid == '0 && !fwd_valid, "R6", "writeback silent", resp_valid, 0);
      send((a + 1) % N, 0, a, '0);
      expect_data((a + 1) % N, 16'hB000 + 16'(a), "R6");
    end

    send(1, 3, 3, 16'h1234);
    chk(resp_valid == '0 && !fwd_valid, "R9", "kind 3 silent", {resp_valid, fwd_valid}, 0);
    send(2, 0, 3, '0);
    expect_data(2, 16'hB003, "R9");

    for (int m = 1; m < 16; m++) begin
      logic [N-1:0] mask;
      mask = 4'(m);
      @(negedge clk);
      req_valid = mask;
      for (int c = 0; c < N; c++) req_kind[2*c +: 2] = 2'd3;
      for (int i = 0; i < 5; i++) begin
        int g;
        #1;
        g = next_grant(mask, rr);
        chk(req_ready == 4'(1 << g), "R8", "round-robin grant", req_ready, 1 << g);
        rr = (g + 1) % N;
        @(negedge clk);
      end
      req_valid = '0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule